// File: doc/BRIEF.md
# Nonvolatile Store/Restore Sequencer

This block moves values between a wiper register (held outside it) and a small nonvolatile word array. It carries out save and restore commands. While an operation runs it drops a ready flag and raises a busy flag, and the serial front end uses the busy flag as its lock. When reset ends, the block loads the stored preset back into the wiper by itself. Word 0 holds the wiper preset. Its reset value is midscale. The two low bits of word 1 drive two latched digital outputs. The remaining words are free for user data.

Each command arrives as a one-cycle strobe with an opcode, an address and a data field. A restore does not write the wiper directly. It sends out a one-cycle load pulse with the value, and the wiper register takes that value. Saves are long and restores are short. Both durations are set by parameters, so that simulation can use small counts. An active-low write-protect input blocks saves to words 0 and 1. An active-low preset input forces midscale while it is held low, and on its rising edge it starts a timed restore.

Top module: `nvm_store_seq`

## Requirements
- R1: While reset is held and for RESTORE_CYC cycles after it ends, rdy_o is 0 and busy_o is 1. In the next cycle load_o pulses for one cycle with load_val_o = 2^(DW-1), which is 512 at DW=10, and rdy_o returns to 1. Both out1_o and out2_o are 0.
- R2: Opcode 4'h2 stores wiper_i into word 0. rdy_o is low for exactly SAVE_CYC cycles.
- R3: Opcode 4'h3 with address 0 stores wiper_i and ignores the data field. With any other address it stores cmd_data_i into that word. Either way rdy_o is low for SAVE_CYC cycles.
- R4: out1_o follows bit 0 of word 1 and out2_o follows bit 1. They change only when a save to address 1 completes.
- R5: Opcode 4'h1 pulses load_o in the cycle after the strobe, with the value of word 0. rdy_o does not drop.
- R6: Opcode 4'h8 holds rdy_o low for RESTORE_CYC cycles. load_o then pulses with word 0 in the first cycle that rdy_o is high again.
- R7: Opcodes 4'h9 and 4'hA hold rdy_o low for RESTORE_CYC cycles. They produce no load pulse and change no stored word.
- R8: A strobe that arrives while busy is ignored. It does not extend the busy time, cause a load or write any word.
- R9: While wp_ni is 0, opcode 4'h2 and opcode 4'h3 aimed at address 0 or 1 are ignored, with no busy period. Restores and saves to addresses 2 and above still run.
- R10: While preset_ni is 0, busy_o is 1 and load_o pulses every cycle with midscale. On its rising edge a restore starts, rdy_o stays low for RESTORE_CYC more cycles, and then load_o pulses with word 0.
- R11: A preset pulse during a save cancels the save, and the target word keeps its old value.
- R12: Opcodes not listed above (4'h0, 4'h4 to 4'h7, 4'hB to 4'hF) cause no busy period, no load pulse and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 4 | Opcode |
| cmd_addr_i | input | AW | Word address |
| cmd_data_i | input | DW | Data field |
| wiper_i | input | DW | Current wiper register value |
| wp_ni | input | 1 | Write protect, active low |
| preset_ni | input | 1 | Hardware preset, active low |
| load_o | output | 1 | Wiper load pulse |
| load_val_o | output | DW | Value to load into the wiper |
| out1_o | output | 1 | Latched output, word 1 bit 0 |
| out2_o | output | 1 | Latched output, word 1 bit 1 |
| rdy_o | output | 1 | High when idle |
| busy_o | output | 1 | Front-end lock, high while an operation runs |

## Verification
The hardest cases are events that arrive partway through a long save: a second strobe, or a preset pulse that has to cancel the commit. The stimulus counts the not-ready cycles of a running save and injects the extra strobes or the preset pulse at chosen counts. It then reads word 0 back with an immediate restore, which shows whether the injected event changed anything. Write protection and the preset word are checked the same way, through a load pulse and the latched outputs.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam logic [3:0] OP_RESTORE   = 4'h1;
  localparam logic [3:0] OP_SAVE_W    = 4'h2;
  localparam logic [3:0] OP_SAVE_A    = 4'h3;
  localparam logic [3:0] OP_RESTORE_T = 4'h8;
  localparam logic [3:0] OP_READ_NV   = 4'h9;
  localparam logic [3:0] OP_READ_W    = 4'hA;

  typedef enum logic [1:0] {
    JOB_IDLE,
    JOB_SAVE,
    JOB_RESTORE,
    JOB_READ
  } job_e;
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int            CW       = 8,
  parameter logic [CW-1:0] INIT_LEN = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          stop_i,
  output logic          active_o,
  output logic          done_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  // power-on: already counting the initial restore
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= INIT_LEN;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= len_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign done_o   = active_q && (cnt_q == '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int NWORDS = 16,
  parameter int DW     = 10,
  parameter int AW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] word0_o,
  output logic [DW-1:0] word1_o
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] mem_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    localparam logic [DW-1:0] RST_VAL = (g == 0) ? MID : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= RST_VAL;
      else if (we_i && waddr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign word0_o = mem_q[0];
  assign word1_o = mem_q[1];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || waddr_i != AW'(1)) |=> $stable(word1_o)); // R4
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DW          = 10,
  parameter int AW          = 4,
  parameter int CW          = 8,
  parameter int SAVE_CYC    = 100,
  parameter int RESTORE_CYC = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [DW-1:0] wiper_i,
  input  logic          wp_ni,
  input  logic          preset_ni,
  input  logic          tmr_active_i,
  input  logic          tmr_done_i,
  input  logic [DW-1:0] word0_i,
  output logic          tmr_start_o,
  output logic [CW-1:0] tmr_len_o,
  output logic          tmr_stop_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          load_o,
  output logic [DW-1:0] load_val_o,
  output logic          busy_o
);
  localparam logic [DW-1:0] MID       = {1'b1, {(DW-1){1'b0}}};
  localparam logic [CW-1:0] SAVE_LEN  = CW'(SAVE_CYC - 1);
  localparam logic [CW-1:0] REST_LEN  = CW'(RESTORE_CYC - 1);

  job_e          job_q, dec_job;
  logic [AW-1:0] addr_q, dec_addr;
  logic [DW-1:0] data_q, dec_data;
  logic [CW-1:0] dec_len;
  logic          dec_start, dec_imm, prot;
  logic          preset_q, load_q;
  logic [DW-1:0] load_val_q;
  logic          pr_low, pr_rise, accept, commit;

  assign pr_low  = !preset_ni;
  assign pr_rise = preset_ni && !preset_q;
  assign accept  = cmd_valid_i && !tmr_active_i && !pr_low && !pr_rise;
  // words 0 and 1 are guarded by write protect
  assign prot    = !wp_ni && ((cmd_addr_i >> 1) == '0);

  always_comb begin
    dec_start = 1'b0;
    dec_imm   = 1'b0;
    dec_job   = JOB_IDLE;
    dec_addr  = cmd_addr_i;
    dec_data  = cmd_data_i;
    dec_len   = REST_LEN;
    unique case (cmd_op_i)
      OP_RESTORE: dec_imm = 1'b1;
      OP_SAVE_W: if (wp_ni) begin
        dec_start = 1'b1;
        dec_job   = JOB_SAVE;
        dec_addr  = '0;
        dec_data  = wiper_i;
        dec_len   = SAVE_LEN;
      end
      OP_SAVE_A: if (!prot) begin
        dec_start = 1'b1;
        dec_job   = JOB_SAVE;
        dec_data  = (cmd_addr_i == '0) ? wiper_i : cmd_data_i;
        dec_len   = SAVE_LEN;
      end
      OP_RESTORE_T: begin
        dec_start = 1'b1;
        dec_job   = JOB_RESTORE;
      end
      OP_READ_NV, OP_READ_W: begin
        dec_start = 1'b1;
        dec_job   = JOB_READ;
      end
      default: ;
    endcase
  end

  assign commit      = tmr_done_i && !pr_low;
  assign tmr_start_o = pr_rise || (accept && dec_start);
  assign tmr_len_o   = pr_rise ? REST_LEN : dec_len;
  assign tmr_stop_o  = pr_low;
  assign we_o        = commit && (job_q == JOB_SAVE);
  assign waddr_o     = addr_q;
  assign wdata_o     = data_q;
  assign busy_o      = tmr_active_i || pr_low || pr_rise;
  assign load_o      = load_q;
  assign load_val_o  = load_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      job_q      <= JOB_RESTORE;
      addr_q     <= '0;
      data_q     <= '0;
      preset_q   <= 1'b1;
      load_q     <= 1'b0;
      load_val_q <= '0;
    end else begin
      preset_q <= preset_ni;
      if (pr_rise) begin
        job_q <= JOB_RESTORE;
      end else if (accept && dec_start) begin
        job_q  <= dec_job;
        addr_q <= dec_addr;
        data_q <= dec_data;
      end
      load_q     <= pr_low || (accept && dec_imm) || (commit && job_q == JOB_RESTORE);
      load_val_q <= pr_low ? MID : word0_i;
    end
  end

  AST_WP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !wp_ni && cmd_op_i == OP_SAVE_W) |=> !tmr_active_i); // R9
  AST_PRESET_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_low |=> (load_o && load_val_o == MID)); // R10
  AST_FAST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_op_i == OP_RESTORE) |=> (load_o && load_val_o == $past(word0_i))); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && tmr_active_i && !pr_low) |=> ($stable(addr_q) && $stable(data_q))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_done_i && !pr_low) |=> !tmr_active_i); // R2
endmodule

// File: rtl/nvm_store_seq.sv
module nvm_store_seq #(
  parameter int DW          = 10,
  parameter int NWORDS      = 16,
  parameter int SAVE_CYC    = 2500000,
  parameter int RESTORE_CYC = 12000,
  localparam int AW         = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [DW-1:0] wiper_i,
  input  logic          wp_ni,
  input  logic          preset_ni,
  output logic          load_o,
  output logic [DW-1:0] load_val_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          rdy_o,
  output logic          busy_o
);
  localparam int            CW       = $clog2(SAVE_CYC + 1);
  localparam logic [CW-1:0] REST_LEN = CW'(RESTORE_CYC - 1);

  logic          tmr_start, tmr_stop, tmr_active, tmr_done, we;
  logic [CW-1:0] tmr_len;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata, word0, word1;

  nvs_timer #(.CW(CW), .INIT_LEN(REST_LEN)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .len_i    (tmr_len),
    .stop_i   (tmr_stop),
    .active_o (tmr_active),
    .done_o   (tmr_done)
  );

  nvs_array #(.NWORDS(NWORDS), .DW(DW), .AW(AW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .word0_o (word0),
    .word1_o (word1)
  );

  nvs_ctrl #(
    .DW(DW), .AW(AW), .CW(CW), .SAVE_CYC(SAVE_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_data_i   (cmd_data_i),
    .wiper_i      (wiper_i),
    .wp_ni        (wp_ni),
    .preset_ni    (preset_ni),
    .tmr_active_i (tmr_active),
    .tmr_done_i   (tmr_done),
    .word0_i      (word0),
    .tmr_start_o  (tmr_start),
    .tmr_len_o    (tmr_len),
    .tmr_stop_o   (tmr_stop),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .load_o       (load_o),
    .load_val_o   (load_val_o),
    .busy_o       (busy_o)
  );

  assign out1_o = word1[0];
  assign out2_o = word1[1];
  assign rdy_o  = !busy_o;
endmodule

// File: tb/nvm_store_seq_test.sv
module nvm_store_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_SAVE    = 12;
  localparam int TB_REST    = 3;
  localparam logic [7:0] SB = 8'(TB_SAVE);
  localparam logic [7:0] RB = 8'(TB_REST);
  localparam int ROWS = 15;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] addr;
    logic [9:0] data;
    logic [9:0] wip;
    logic       wp;
    logic [7:0] busy;
    logic       ld;
    logic [9:0] ldv;
    logic [9:0] w0;
    logic [1:0] outs;
  } vec_t;

  // op, addr, data, wiper, wp_n, busy cycles, load?, load value, word0 after, {out2,out1} after
  localparam logic [59:0] TBL [ROWS] = '{
    {4'h3, 4'h0, 10'h0AB, 10'h155, 1'b1, SB,    1'b0, 10'h000, 10'h155, 2'd0}, // R3
    {4'h3, 4'h1, 10'h001, 10'h000, 1'b1, SB,    1'b0, 10'h000, 10'h155, 2'd1}, // R4
    {4'h3, 4'h1, 10'h3FE, 10'h000, 1'b1, SB,    1'b0, 10'h000, 10'h155, 2'd2}, // R4
    {4'h2, 4'h0, 10'h000, 10'h2AA, 1'b0, 8'd0,  1'b0, 10'h000, 10'h155, 2'd2}, // R9
    {4'h3, 4'h1, 10'h003, 10'h000, 1'b0, 8'd0,  1'b0, 10'h000, 10'h155, 2'd2}, // R9
    {4'h8, 4'h0, 10'h000, 10'h000, 1'b0, RB,    1'b1, 10'h155, 10'h155, 2'd2}, // R6
    {4'h2, 4'h0, 10'h000, 10'h3FF, 1'b1, SB,    1'b0, 10'h000, 10'h3FF, 2'd2}, // R2
    {4'h9, 4'h0, 10'h000, 10'h000, 1'b1, RB,    1'b0, 10'h000, 10'h3FF, 2'd2}, // R7
    {4'hA, 4'h1, 10'h003, 10'h000, 1'b1, RB,    1'b0, 10'h000, 10'h3FF, 2'd2}, // R7
    {4'h0, 4'h1, 10'h003, 10'h000, 1'b1, 8'd0,  1'b0, 10'h000, 10'h3FF, 2'd2}, // R12
    {4'hB, 4'h1, 10'h003, 10'h155, 1'b1, 8'd0,  1'b0, 10'h000, 10'h3FF, 2'd2}, // R12
    {4'h1, 4'h0, 10'h000, 10'h000, 1'b1, 8'd0,  1'b1, 10'h3FF, 10'h3FF, 2'd2}, // R5
    {4'h3, 4'h0, 10'h0AB, 10'h010, 1'b1, SB,    1'b0, 10'h000, 10'h010, 2'd2}, // R3
    {4'h3, 4'h1, 10'h003, 10'h000, 1'b1, SB,    1'b0, 10'h000, 10'h010, 2'd3}, // R4
    {4'h3, 4'h7, 10'h155, 10'h000, 1'b0, SB,    1'b0, 10'h000, 10'h010, 2'd3}  // R9
  };

  function automatic string row_tag(int i);
    case (i)
      0, 12:    return "R3";
      1, 2, 13: return "R4";
      3, 4, 14: return "R9";
      5:        return "R6";
      6:        return "R2";
      7, 8:     return "R7";
      9, 10:    return "R12";
      default:  return "R5";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [3:0] cmd_addr = '0;
  logic [9:0] cmd_data = '0;
  logic [9:0] wiper = '0;
  logic       wp_n = 1'b1;
  logic       preset_n = 1'b1;
  logic       load_o, out1_o, out2_o, rdy_o, busy_o;
  logic [9:0] load_val_o;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_store_seq #(.DW(10), .NWORDS(16), .SAVE_CYC(TB_SAVE), .RESTORE_CYC(TB_REST)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .wiper_i(wiper), .wp_ni(wp_n),
    .preset_ni(preset_n), .load_o(load_o), .load_val_o(load_val_o),
    .out1_o(out1_o), .out2_o(out2_o), .rdy_o(rdy_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic [3:0] a, input logic [9:0] d,
                         input logic [9:0] w, input logic wp, output int bcnt,
                         output logic ld, output logic [9:0] ldv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; wiper = w; wp_n = wp;
    @(negedge clk);
    cmd_valid = 1'b0;
    bcnt = 0; ld = 1'b0; ldv = '0;
    while (!rdy_o && bcnt < 1000) begin
      bcnt++;
      if (load_o) begin ld = 1'b1; ldv = load_val_o; end
      @(negedge clk);
    end
    if (load_o) begin ld = 1'b1; ldv = load_val_o; end
    wp_n = 1'b1;
  endtask

  task automatic verify(input string req, input logic [9:0] exp_w0, input logic [1:0] exp_outs);
    int b; logic ld; logic [9:0] v;
    run_cmd(4'h1, 4'h0, 10'h0, 10'h0, 1'b1, b, ld, v);
    chk({req, " readback load"}, int'(ld), 1);
    chk({req, " word0"}, int'(v), int'(exp_w0));
    chk({req, " outputs"}, int'({out2_o, out1_o}), int'(exp_outs));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b, k;
    logic ld, seen;
    logic [9:0] v;
    vec_t r;

    // R1: reset state and power-on restore
    repeat (2) @(negedge clk);
    chk("R1 rdy in reset", int'(rdy_o), 0);
    chk("R1 busy in reset", int'(busy_o), 1);
    rst_ni = 1'b1;
    k = 0;
    while (!load_o && k < 100) begin @(negedge clk); k++; end
    chk("R1 load delay", k, TB_REST);
    chk("R1 midscale", int'(load_val_o), 512);
    chk("R1 rdy after restore", int'(rdy_o), 1);
    chk("R1 outputs", int'({out2_o, out1_o}), 0);

    for (int i = 0; i < ROWS; i++) begin
      r = vec_t'(TBL[i]);
      run_cmd(r.op, r.addr, r.data, r.wip, r.wp, b, ld, v);
      chk({row_tag(i), " busy cycles"}, b, int'(r.busy));
      chk({row_tag(i), " load flag"}, int'(ld), int'(r.ld));
      if (r.ld) chk({row_tag(i), " load value"}, int'(v), int'(r.ldv));
      verify(row_tag(i), r.w0, r.outs);
    end

    // R8: strobes during a save are dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'h2; wiper = 10'h0C3; wp_n = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    b = 0; seen = 1'b0;
    while (!rdy_o && b < 1000) begin
      b++;
      if (load_o) seen = 1'b1;
      cmd_valid = (b == 3) || (b == 4);
      cmd_op = (b == 3) ? 4'h3 : 4'h1;
      cmd_addr = 4'h1; cmd_data = 10'h000;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R8 busy length", b, TB_SAVE);
    chk("R8 no load while busy", int'(seen), 0);
    verify("R8", 10'h0C3, 2'd3);

    // R10: preset pulse
    @(negedge clk);
    preset_n = 1'b0;
    @(negedge clk);
    chk("R10 load while low", int'(load_o), 1);
    chk("R10 midscale while low", int'(load_val_o), 512);
    chk("R10 rdy while low", int'(rdy_o), 0);
    @(negedge clk);
    chk("R10 load repeats", int'(load_o), 1);
    preset_n = 1'b1;
    @(negedge clk);
    b = 0;
    while (!rdy_o && b < 1000) begin b++; @(negedge clk); end
    chk("R10 restore length", b, TB_REST);
    chk("R10 restore load", int'(load_o), 1);
    chk("R10 restore value", int'(load_val_o), 'h0C3);

    // R11: preset during save cancels the commit
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'h2; wiper = 10'h111;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    preset_n = 1'b0;
    repeat (2) @(negedge clk);
    preset_n = 1'b1;
    @(negedge clk);
    b = 0;
    while (!rdy_o && b < 1000) begin b++; @(negedge clk); end
    chk("R11 restore load", int'(load_o), 1);
    chk("R11 old value restored", int'(load_val_o), 'h0C3);
    verify("R11", 10'h0C3, 2'd3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule